// File: doc/BRIEF.md
# Power-Fail Chip-Enable Conditioner

This block sits between a host's single active-low memory chip enable and up to four battery-backed static RAMs. In normal operation it decodes two select bits into one of four active-low conditioned enables, so that exactly one memory sees the access. A digital supply-valid flag from an external voltage comparator tells the block whether the supply is inside its tolerance band. When the flag drops, the block write-protects every memory by holding all conditioned enables high. An access that is already under way is allowed to run on for a bounded grace window before the outputs are forced high.

The block also produces a power-on reset request for the host. It is active low and is meant to drive an open-drain pad. The request is asserted while the supply is bad. After the supply returns it is held for a fixed interval, and the memories stay blocked for a separate fixed interval. All durations are parameters counted in clock ticks. The grace window is `GRACE_TICKS`, the enable hold-off is `HOLD_TICKS` and the reset hold is `RST_TICKS`, each at least 1. Inputs are sampled on the rising clock edge and both outputs are registered, so every response appears after the edge that sampled its cause.

Top module: `cecond_top`

## Requirements
- R1: When `ce_n` is sampled high at a rising edge, all four bits of `ce_out_n` are high after that edge.
- R2: In normal operation, when `ce_n` is sampled low, exactly one bit of `ce_out_n` is low after that edge. The bit is index {sel_b,sel_a]: 00 selects bit 0, 01 selects bit 1, 10 selects bit 2 and 11 selects bit 3.
- R3: The select is captured at the first edge at which `ce_n` is sampled low. Select changes while `ce_n` stays low do not move the active output.
- R4: After `rst`, all bits of `ce_out_n` are high and `por_req_n` is low. Both stay that way, whatever `ce_n` does, until the supply has been valid for the hold intervals.
- R5: While `supply_ok` is low and no access is in progress, a new falling `ce_n` produces no low bit on `ce_out_n`.
- R6: If `ce_n` is low at the edge where `supply_ok` is first sampled low (edge d), the selected output stays low until `ce_n` is sampled high. If `ce_n` stays low, the output is forced high from edge d+GRACE_TICKS.
- R7: `por_req_n` is low from the second edge after `supply_ok` is first sampled low, and stays low while the supply is invalid.
- R8: Edge 1 is the first edge at which `supply_ok` is sampled high after a power-bad period, and `supply_ok` stays high from then on. `ce_out_n` stays all high through edge HOLD_TICKS and follows `ce_n` from edge HOLD_TICKS+1.
- R9: Counting edges in the same way, `por_req_n` stays low through edge RST_TICKS and is high from edge RST_TICKS+1.
- R10: If `supply_ok` drops during the recovery interval, the interval restarts from zero when the supply next becomes valid.
- R11: During the grace window, once the interrupted access ends, lowering `ce_n` again produces no low bit on `ce_out_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | High while the external comparator sees a valid supply |
| ce_n | input | 1 | Active-low chip enable from the host |
| sel_a | input | 1 | Select bit, low-order |
| sel_b | input | 1 | Select bit, high-order |
| ce_out_n | output | 4 | Active-low conditioned chip enables, one per memory |
| por_req_n | output | 1 | Active-low reset request to the open-drain pad |

## Verification
The bench places exact checks on the edges where the recovery hold-offs end. A counter that is off by one would show its outputs opening or reset releasing one edge early or late. It changes the select in the middle of an access: a design that decodes the live select would move the enable onto another memory halfway through a cycle. It interrupts the recovery interval with a supply dip, so a counter that is not cleared would unblock the memories too soon. It ends power-fail grace windows in both ways, by the access ending and by the timeout. It then re-asserts the chip enable inside the window, which catches a design that lets a second access through or leaves the enable stuck low past the window.

// File: rtl/cecond_pkg.sv
package cecond_pkg;
  typedef enum logic [1:0] {
    ST_BAD     = 2'd0,
    ST_RECOVER = 2'd1,
    ST_RUN     = 2'd2,
    ST_GRACE   = 2'd3
  } pwr_state_e;
endpackage

// File: rtl/cecond_seq.sv
// Supply sequencer: tracks power state, recovery hold-off and grace window.
module cecond_seq
  import cecond_pkg::*;
#(
  parameter int unsigned GRACE_TICKS = 50000,
  parameter int unsigned HOLD_TICKS  = 16000000,
  parameter int unsigned RST_TICKS   = 16000000
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok,
  input  logic ce_n,
  output logic gate_open,
  output logic por_req_n
);
  localparam int unsigned LONG_T = (HOLD_TICKS > RST_TICKS) ? HOLD_TICKS : RST_TICKS;
  localparam int CW = $clog2(LONG_T + 2);
  localparam int GW = $clog2(GRACE_TICKS + 2);
  localparam logic [CW-1:0] HOLD_C  = CW'(HOLD_TICKS);
  localparam logic [CW-1:0] RST_C   = CW'(RST_TICKS);
  localparam logic [CW-1:0] LONG_C  = CW'(LONG_T);
  localparam logic [GW-1:0] GRACE_C = GW'(GRACE_TICKS);

  pwr_state_e    state;
  logic [CW-1:0] rec_cnt;
  logic [GW-1:0] grace_cnt;
  logic          release_now;
  logic          por_q;

  always_comb begin
    gate_open   = 1'b0;
    release_now = 1'b0;
    unique case (state)
      ST_RUN: begin
        gate_open   = 1'b1;
        release_now = 1'b1;
      end
      ST_RECOVER: begin
        gate_open   = (rec_cnt >= HOLD_C);
        release_now = (rec_cnt >= RST_C);
      end
      ST_GRACE: gate_open = (grace_cnt < GRACE_C);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_BAD;
      rec_cnt   <= '0;
      grace_cnt <= '0;
      por_q     <= 1'b0;
    end else begin
      por_q <= release_now;
      unique case (state)
        ST_BAD: begin
          if (supply_ok) begin
            state   <= ST_RECOVER;
            rec_cnt <= CW'(1);
          end
        end
        ST_RECOVER: begin
          if (!supply_ok) begin
            state   <= ST_BAD;
            rec_cnt <= '0;
          end else if (rec_cnt >= LONG_C) begin
            state <= ST_RUN;
          end else begin
            rec_cnt <= rec_cnt + 1'b1;
          end
        end
        ST_RUN: begin
          if (!supply_ok) begin
            rec_cnt <= '0;
            if (!ce_n) begin
              state     <= ST_GRACE;
              grace_cnt <= GW'(1);
            end else begin
              state <= ST_BAD;
            end
          end
        end
        ST_GRACE: begin
          if (ce_n || (grace_cnt >= GRACE_C)) begin
            state     <= ST_BAD;
            grace_cnt <= '0;
          end else begin
            grace_cnt <= grace_cnt + 1'b1;
          end
        end
        default: state <= ST_BAD;
      endcase
    end
  end

  assign por_req_n = por_q;
endmodule

// File: rtl/cecond_route.sv
// Select capture and one-of-N decode onto registered active-low enables.
module cecond_route #(
  parameter int SEL_W   = 2,
  parameter int NUM_OUT = 1 << SEL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ce_n,
  input  logic [SEL_W-1:0]   sel,
  input  logic               gate_open,
  output logic [NUM_OUT-1:0] ce_out_n
);
  logic               ce_prev_n;
  logic [SEL_W-1:0]   sel_hold;
  logic [SEL_W-1:0]   eff_sel;
  logic [NUM_OUT-1:0] hit;

  // Live select while idle; held copy once an access has begun.
  assign eff_sel = ce_prev_n ? sel : sel_hold;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_dec
    assign hit[i] = (eff_sel == SEL_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_prev_n <= 1'b1;
      sel_hold  <= '0;
      ce_out_n  <= '1;
    end else begin
      ce_prev_n <= ce_n;
      sel_hold  <= eff_sel;
      ce_out_n  <= (gate_open && !ce_n) ? ~hit : '1;
    end
  end
endmodule

// File: rtl/cecond_top.sv
module cecond_top #(
  parameter int unsigned GRACE_TICKS = 50000,
  parameter int unsigned HOLD_TICKS  = 16000000,
  parameter int unsigned RST_TICKS   = 16000000,
  localparam int SEL_W   = 2,
  localparam int NUM_OUT = 1 << SEL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               supply_ok,
  input  logic               ce_n,
  input  logic               sel_a,
  input  logic               sel_b,
  output logic [NUM_OUT-1:0] ce_out_n,
  output logic               por_req_n
);
  logic gate_open;

  cecond_seq #(
    .GRACE_TICKS(GRACE_TICKS),
    .HOLD_TICKS (HOLD_TICKS),
    .RST_TICKS  (RST_TICKS)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .supply_ok(supply_ok),
    .ce_n     (ce_n),
    .gate_open(gate_open),
    .por_req_n(por_req_n)
  );

  cecond_route #(
    .SEL_W  (SEL_W),
    .NUM_OUT(NUM_OUT)
  ) u_route (
    .clk      (clk),
    .rst      (rst),
    .ce_n     (ce_n),
    .sel      ({sel_b, sel_a}),
    .gate_open(gate_open),
    .ce_out_n (ce_out_n)
  );
endmodule

// File: rtl/cecond_chk.sv
module cecond_chk #(
  parameter int unsigned GRACE_TICKS = 50000
) (
  input logic       clk,
  input logic       rst,
  input logic       supply_ok,
  input logic       ce_n,
  input logic [3:0] ce_out_n,
  input logic       por_req_n
);
  // Length of the current stretch with the supply bad and an enable low.
  logic [31:0] bad_active;

  always_ff @(posedge clk) begin
    if (rst) bad_active <= '0;
    else     bad_active <= (!supply_ok && !(&ce_out_n)) ? bad_active + 1 : '0;
  end

  AST_IDLE_ALL_HIGH: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> (&ce_out_n)); // R1

  AST_AT_MOST_ONE: assert property (@(posedge clk) disable iff (rst)
    $countones(~ce_out_n) <= 1); // R2

  AST_SEL_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (!(&ce_out_n) && !(&$past(ce_out_n))) |-> (ce_out_n == $past(ce_out_n))); // R3

  AST_NO_NEW_WHEN_BAD: assert property (@(posedge clk) disable iff (rst)
    (ce_n && !supply_ok) |=> ##1 (&ce_out_n)); // R5

  AST_GRACE_BOUND: assert property (@(posedge clk) disable iff (rst)
    bad_active <= 32'(GRACE_TICKS + 1)); // R6

  AST_POR_ON_FAIL: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> ##1 !por_req_n); // R7
endmodule

bind cecond_top cecond_chk #(.GRACE_TICKS(GRACE_TICKS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .supply_ok(supply_ok),
  .ce_n     (ce_n),
  .ce_out_n (ce_out_n),
  .por_req_n(por_req_n)
);

// File: tb/cecond_top_tb.sv
`timescale 1ns/1ps
module cecond_top_tb;
  localparam int GRACE = 5;
  localparam int HOLD  = 8;
  localparam int RSTT  = 12;
  localparam int LONG  = (HOLD > RSTT) ? HOLD : RSTT;
  localparam int NV    = 11;

  // {tag[1:0] (0=R1,1=R2,2=R3), ce_n, sel_b, sel_a, expected ce_out_n[3:0]}
  localparam logic [8:0] VEC [0:NV-1] = '{
    {2'd0, 1'b1, 1'b0, 1'b0, 4'hF},
    {2'd1, 1'b0, 1'b0, 1'b0, 4'hE},
    {2'd0, 1'b1, 1'b0, 1'b1, 4'hF},
    {2'd1, 1'b0, 1'b0, 1'b1, 4'hD},
    {2'd0, 1'b1, 1'b1, 1'b0, 4'hF},
    {2'd1, 1'b0, 1'b1, 1'b0, 4'hB},
    {2'd2, 1'b0, 1'b0, 1'b0, 4'hB},
    {2'd2, 1'b0, 1'b1, 1'b1, 4'hB},
    {2'd0, 1'b1, 1'b1, 1'b1, 4'hF},
    {2'd1, 1'b0, 1'b1, 1'b1, 4'h7},
    {2'd0, 1'b1, 1'b0, 1'b0, 4'hF}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       supply_ok = 1'b0;
  logic       ce_n = 1'b1;
  logic       sel_a = 1'b0;
  logic       sel_b = 1'b0;
  logic [3:0] ce_out_n;
  logic       por_req_n;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  always #2.5 clk = ~clk;

  cecond_top #(
    .GRACE_TICKS(GRACE),
    .HOLD_TICKS (HOLD),
    .RST_TICKS  (RSTT)
  ) u_dut (
    .clk      (clk),
    .rst      (rst),
    .supply_ok(supply_ok),
    .ce_n     (ce_n),
    .sel_a    (sel_a),
    .sel_b    (sel_b),
    .ce_out_n (ce_out_n),
    .por_req_n(por_req_n)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic recover();
    supply_ok = 1'b1;
    ce_n      = 1'b1;
    repeat (LONG + 3) tick();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R4: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) tick();
    rst = 1'b0;
    tick();
    chk("R4", "outputs after reset", 32'(ce_out_n), 32'hF);
    chk("R4", "reset request after reset", 32'(por_req_n), 32'h0);
    ce_n = 1'b0;
    repeat (4) tick();
    chk("R4", "access while never powered", 32'(ce_out_n), 32'hF);
    ce_n = 1'b1;
    tick();

    // First recovery with an access pending on select 2.
    supply_ok = 1'b1;
    ce_n = 1'b0; sel_b = 1'b1; sel_a = 1'b0;
    for (int k = 1; k <= LONG + 2; k++) begin
      tick();
      if (k == HOLD)     chk("R8", "still blocked at hold end", 32'(ce_out_n), 32'hF);
      if (k == HOLD + 1) chk("R8", "open after hold", 32'(ce_out_n), 32'hB);
      if (k == RSTT)     chk("R9", "reset held at end", 32'(por_req_n), 32'h0);
      if (k == RSTT + 1) chk("R9", "reset released", 32'(por_req_n), 32'h1);
    end
    ce_n = 1'b1;
    tick();

    // Normal decode vectors.
    for (int i = 0; i < NV; i++) begin
      string tg;
      ce_n  = VEC[i][6];
      sel_b = VEC[i][5];
      sel_a = VEC[i][4];
      tick();
      case (VEC[i][8:7])
        2'd0:    tg = "R1";
        2'd1:    tg = "R2";
        default: tg = "R3";
      endcase
      chk(tg, $sformatf("vector %0d", i), 32'(ce_out_n), 32'(VEC[i][3:0]));
    end

    // Power fails with no access; a later access is blocked.
    ce_n = 1'b1;
    supply_ok = 1'b0;
    tick();
    ce_n = 1'b0; sel_b = 1'b0; sel_a = 1'b0;
    tick();
    chk("R5", "new access while bad", 32'(ce_out_n), 32'hF);
    chk("R7", "reset request on fail", 32'(por_req_n), 32'h0);
    repeat (3) tick();
    chk("R5", "still blocked", 32'(ce_out_n), 32'hF);
    chk("R7", "reset held while bad", 32'(por_req_n), 32'h0);

    // Recovery interrupted by a dip; the interval must restart.
    ce_n = 1'b1;
    supply_ok = 1'b1;
    repeat (5) tick();
    supply_ok = 1'b0;
    repeat (2) tick();
    supply_ok = 1'b1;
    ce_n = 1'b0; sel_b = 1'b0; sel_a = 1'b1;
    for (int k = 1; k <= HOLD + 1; k++) begin
      tick();
      if (k == HOLD)     chk("R10", "blocked after restart", 32'(ce_out_n), 32'hF);
      if (k == HOLD + 1) chk("R10", "open after full interval", 32'(ce_out_n), 32'hD);
    end
    repeat (LONG) tick();
    ce_n = 1'b1;
    tick();

    // Grace window ended by the access itself.
    ce_n = 1'b0; sel_b = 1'b0; sel_a = 1'b1;
    tick();
    chk("R2", "access before fail", 32'(ce_out_n), 32'hD);
    supply_ok = 1'b0;
    tick();
    chk("R6", "access continues at fail", 32'(ce_out_n), 32'hD);
    repeat (2) tick();
    chk("R6", "access continues in window", 32'(ce_out_n), 32'hD);
    ce_n = 1'b1;
    tick();
    chk("R6", "access ended", 32'(ce_out_n), 32'hF);
    ce_n = 1'b0;
    tick();
    chk("R11", "second access in window", 32'(ce_out_n), 32'hF);
    tick();
    chk("R11", "second access still blocked", 32'(ce_out_n), 32'hF);
    chk("R7", "reset request in window", 32'(por_req_n), 32'h0);
    recover();

    // Grace window ended by timeout.
    ce_n = 1'b0; sel_b = 1'b1; sel_a = 1'b1;
    tick();
    chk("R2", "access select 3", 32'(ce_out_n), 32'h7);
    supply_ok = 1'b0;
    tick();
    for (int k = 1; k <= GRACE; k++) begin
      tick();
      if (k == GRACE - 1) chk("R6", "low before timeout", 32'(ce_out_n), 32'h7);
      if (k == GRACE)     chk("R6", "forced high at timeout", 32'(ce_out_n), 32'hF);
    end
    chk("R7", "reset request after timeout", 32'(por_req_n), 32'h0);

    // Full recovery, then a reset while running.
    recover();
    chk("R9", "reset released after recovery", 32'(por_req_n), 32'h1);
    ce_n = 1'b0;
    rst = 1'b1;
    repeat (2) tick();
    rst = 1'b0;
    tick();
    chk("R4", "outputs after mid-run reset", 32'(ce_out_n), 32'hF);
    chk("R4", "reset request after mid-run reset", 32'(por_req_n), 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule